// File: doc/BRIEF.md
# Slot-Driven Two-Lane Word Mover

This block carries out precompiled word transfers for a time-slotted network node. Each clock, an upstream slot sequencer may hand each of two independent lanes a stream number. The lane looks up that stream's instruction in its own instruction table. The instruction names one source and one destination among the four neighbour ports and a local processor register. The lane reads the source word into a holding register on the following cycle and writes that word to the destination on the cycle after that.

Routing comes entirely from the instruction selected by the slot. The data word is never examined, so every word has the same fixed latency. Because the two lanes run side by side, two reads and two writes can happen in one cycle, which keeps all four ports busy.

Top module: `stream_xfer_pipe`

## Requirements
- R1: After reset, no read enable and no write enable is asserted, `dst_conflict` is 0 and `proc_reg` is 0. Every entry of both instruction tables reads as null source and null destination.
- R2: When `ld_en` is 1 at a clock edge, the entry `ld_addr` of the table chosen by `ld_pipe` (0 or 1) is set to source `ld_src` and destination `ld_dst`. The other lane's table is left as it was.
- R3: Selector codes are 3 bits. Codes 0 to 3 name ports 0 to 3, code 4 names the processor register, and codes 5, 6 and 7 are null.
- R4: Suppose lane p is given a valid stream at edge t and that stream's source is a port. Then that port's bit of `port_rd_en` is high in the cycle after edge t, and the word on that port's slice of `port_rd_data` is captured at the next edge.
- R5: In the cycle after the capture, the destination port's bit of `port_wr_en` is high and its slice of `port_wr_data` carries the captured word unchanged. Any port slice without a write enable reads zero, and at most two write enables are high at once.
- R6: A slot whose valid bit is 0 is a bubble. It produces no read enable, no write enable and no change to `proc_reg`.
- R7: The two lanes work concurrently and each uses its own table. Two transfers between disjoint port pairs in the same slot drive all four ports in the same cycle.
- R8: If both lanes write the same non-null destination in the same cycle, lane 0's word is written and `dst_conflict` is 1 for that cycle only.
- R9: The processor register is readable as source code 4 and writable as destination code 4, and its value is visible on `proc_reg` one cycle after the write. A processor write (`proc_wr_en`) in the same cycle as a lane write wins.
- R10: A null source delivers a zero word to its destination. A null destination causes no write anywhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid | input | 2 | Per-lane slot valid |
| slot_stream | input | 2*IDX_W | Per-lane stream number, lane p at bits [p*IDX_W +: IDX_W] |
| ld_en | input | 1 | Instruction table write strobe |
| ld_pipe | input | 1 | Lane whose table is written |
| ld_addr | input | IDX_W | Stream entry to write |
| ld_src | input | 3 | Source selector to store |
| ld_dst | input | 3 | Destination selector to store |
| port_rd_data | input | 4*DATA_W | Incoming words, port k at [k*DATA_W +: DATA_W] |
| port_rd_en | output | 4 | Per-port read strobe |
| port_wr_data | output | 4*DATA_W | Outgoing words, port k at [k*DATA_W +: DATA_W] |
| port_wr_en | output | 4 | Per-port write strobe |
| proc_wr_en | input | 1 | Processor write to the local register |
| proc_wr_data | input | DATA_W | Processor write data |
| proc_reg | output | DATA_W | Local processor register value |
| dst_conflict | output | 1 | Both lanes targeted the same destination this cycle |

## Verification
The bench goes after several corner cases. The first is two lanes hitting the same destination: a design with the wrong priority would emit lane 1's word, and one without a flag would leave the collision silent. The second is the processor register as both source and sink: a stale read would show up as a word that is one update late, and a wrong override order would lose the processor's own write. The third is null selectors and bubbles: a design that decodes codes 5 to 7 as ports, or ignores the valid bit, would strobe a port that should stay idle. The fourth is timing: a design that shifts the read or write by one stage would show enables in the wrong cycle against the cycle-exact reference model.

// File: rtl/stx_pkg.sv
package stx_pkg;
    localparam int SEL_W     = 3;
    localparam int NUM_PORTS = 4;
    localparam int NUM_LANES = 2;

    localparam logic [SEL_W-1:0] SEL_PROC = 3'd4;
    localparam logic [SEL_W-1:0] SEL_NONE = 3'd7;

    typedef struct packed {
        logic [SEL_W-1:0] src;
        logic [SEL_W-1:0] dst;
    } xfer_instr_t;

    function automatic logic sel_is_port(input logic [SEL_W-1:0] sel);
        return sel < SEL_W'(NUM_PORTS);
    endfunction

    function automatic logic sel_is_real(input logic [SEL_W-1:0] sel);
        return sel <= SEL_PROC;
    endfunction
endpackage

// File: rtl/stx_instr_store.sv
module stx_instr_store
    import stx_pkg::*;
#(
    parameter int NUM_STREAMS = 32,
    localparam int IDX_W = $clog2(NUM_STREAMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_addr,
    input  xfer_instr_t       ld_instr,
    input  logic              slot_valid,
    input  logic [IDX_W-1:0]  slot_idx,
    output logic              s2_valid,
    output xfer_instr_t       s2_instr
);
    typedef struct packed {
        xfer_instr_t [NUM_STREAMS-1:0] table_;
        logic                          vld;
        xfer_instr_t                   ins;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = slot_valid;
        st_d.ins = slot_valid ? st_q.table_[slot_idx] : '{src: SEL_NONE, dst: SEL_NONE};
        if (ld_en) begin
            st_d.table_[ld_addr] = ld_instr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_STREAMS; i++) begin
                st_q.table_[i] <= '{src: SEL_NONE, dst: SEL_NONE};
            end
            st_q.vld <= 1'b0;
            st_q.ins <= '{src: SEL_NONE, dst: SEL_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign s2_valid = st_q.vld;
    assign s2_instr = st_q.ins;
endmodule

// File: rtl/stx_hold_stage.sv
module stx_hold_stage
    import stx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s2_valid,
    input  xfer_instr_t                   s2_instr,
    input  logic [NUM_PORTS*DATA_W-1:0]   port_rd_data,
    input  logic [DATA_W-1:0]             proc_word,
    output logic                          s3_valid,
    output logic [SEL_W-1:0]              s3_dst,
    output logic [DATA_W-1:0]             s3_word
);
    typedef struct packed {
        logic              vld;
        logic [SEL_W-1:0]  dst;
        logic [DATA_W-1:0] word;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic [DATA_W-1:0] src_word;

    always_comb begin
        src_word = '0;
        if (sel_is_port(s2_instr.src)) begin
            src_word = port_rd_data[int'(s2_instr.src)*DATA_W +: DATA_W];
        end else if (s2_instr.src == SEL_PROC) begin
            src_word = proc_word;
        end
        st_d.vld  = s2_valid;
        st_d.dst  = s2_valid ? s2_instr.dst : SEL_NONE;
        st_d.word = s2_valid ? src_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, dst: SEL_NONE, word: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign s3_valid = st_q.vld;
    assign s3_dst   = st_q.dst;
    assign s3_word  = st_q.word;
endmodule

// File: rtl/stream_xfer_pipe.sv
module stream_xfer_pipe
    import stx_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int NUM_STREAMS = 32,
    localparam int IDX_W = $clog2(NUM_STREAMS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LANES-1:0]          slot_valid,
    input  logic [NUM_LANES*IDX_W-1:0]    slot_stream,
    input  logic                          ld_en,
    input  logic                          ld_pipe,
    input  logic [IDX_W-1:0]              ld_addr,
    input  logic [SEL_W-1:0]              ld_src,
    input  logic [SEL_W-1:0]              ld_dst,
    input  logic [NUM_PORTS*DATA_W-1:0]   port_rd_data,
    output logic [NUM_PORTS-1:0]          port_rd_en,
    output logic [NUM_PORTS*DATA_W-1:0]   port_wr_data,
    output logic [NUM_PORTS-1:0]          port_wr_en,
    input  logic                          proc_wr_en,
    input  logic [DATA_W-1:0]             proc_wr_data,
    output logic [DATA_W-1:0]             proc_reg,
    output logic                          dst_conflict
);
    typedef struct packed {
        logic [DATA_W-1:0] proc;
    } top_st_t;

    top_st_t st_d, st_q;

    logic        [NUM_LANES-1:0] s2_valid;
    xfer_instr_t [NUM_LANES-1:0] s2_instr;
    logic        [NUM_LANES-1:0] s3_valid;
    logic [NUM_LANES-1:0][SEL_W-1:0]  s3_dst;
    logic [NUM_LANES-1:0][DATA_W-1:0] s3_word;

    for (genvar p = 0; p < NUM_LANES; p++) begin : g_lane
        stx_instr_store #(.NUM_STREAMS(NUM_STREAMS)) store_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .ld_en      (ld_en && (ld_pipe == 1'(p))),
            .ld_addr    (ld_addr),
            .ld_instr   ('{src: ld_src, dst: ld_dst}),
            .slot_valid (slot_valid[p]),
            .slot_idx   (slot_stream[p*IDX_W +: IDX_W]),
            .s2_valid   (s2_valid[p]),
            .s2_instr   (s2_instr[p])
        );

        stx_hold_stage #(.DATA_W(DATA_W)) hold_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .s2_valid     (s2_valid[p]),
            .s2_instr     (s2_instr[p]),
            .port_rd_data (port_rd_data),
            .proc_word    (st_q.proc),
            .s3_valid     (s3_valid[p]),
            .s3_dst       (s3_dst[p]),
            .s3_word      (s3_word[p])
        );
    end

    always_comb begin
        port_rd_en   = '0;
        port_wr_en   = '0;
        port_wr_data = '0;
        st_d         = st_q;
        for (int p = 0; p < NUM_LANES; p++) begin
            if (s2_valid[p] && sel_is_port(s2_instr[p].src)) begin
                port_rd_en[s2_instr[p].src[1:0]] = 1'b1;
            end
        end
        // lane 0 is visited last so that its write takes priority
        for (int p = NUM_LANES - 1; p >= 0; p--) begin
            if (s3_valid[p] && sel_is_port(s3_dst[p])) begin
                port_wr_en[s3_dst[p][1:0]] = 1'b1;
                port_wr_data[int'(s3_dst[p])*DATA_W +: DATA_W] = s3_word[p];
            end else if (s3_valid[p] && s3_dst[p] == SEL_PROC) begin
                st_d.proc = s3_word[p];
            end
        end
        if (proc_wr_en) begin
            st_d.proc = proc_wr_data;
        end
        dst_conflict = s3_valid[0] && s3_valid[1] &&
                       (s3_dst[0] == s3_dst[1]) && sel_is_real(s3_dst[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{proc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign proc_reg = st_q.proc;
endmodule

// File: rtl/stx_pipe_chk.sv
module stx_pipe_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        slot_valid,
    input logic [3:0]        port_rd_en,
    input logic [3:0]        port_wr_en,
    input logic              dst_conflict,
    input logic              proc_wr_en,
    input logic [DATA_W-1:0] proc_wr_data,
    input logic [DATA_W-1:0] proc_reg
);
    // R4
    rd_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_rd_en) |-> $past(|slot_valid));

    // R6
    wr_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_wr_en) |-> $past(|slot_valid, 2));

    // R5
    wr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(port_wr_en) <= 2);

    // R8
    conflict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_conflict |-> $past(&slot_valid, 2));

    // R9
    proc_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proc_wr_en |=> proc_reg == $past(proc_wr_data));
endmodule

bind stream_xfer_pipe stx_pipe_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_valid   (slot_valid),
    .port_rd_en   (port_rd_en),
    .port_wr_en   (port_wr_en),
    .dst_conflict (dst_conflict),
    .proc_wr_en   (proc_wr_en),
    .proc_wr_data (proc_wr_data),
    .proc_reg     (proc_reg)
);

// File: tb/stream_xfer_pipe_tb_top.sv
module stream_xfer_pipe_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 32;
    localparam int NS  = 32;
    localparam int IW  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    slot_valid = '0;
    logic [2*IW-1:0] slot_stream = '0;
    logic          ld_en = 1'b0;
    logic          ld_pipe = 1'b0;
    logic [IW-1:0] ld_addr = '0;
    logic [2:0]    ld_src = '0;
    logic [2:0]    ld_dst = '0;
    logic [4*W-1:0] port_rd_data = '0;
    logic [3:0]    port_rd_en;
    logic [4*W-1:0] port_wr_data;
    logic [3:0]    port_wr_en;
    logic          proc_wr_en = 1'b0;
    logic [W-1:0]  proc_wr_data = '0;
    logic [W-1:0]  proc_reg;
    logic          dst_conflict;

    int vectors = 0;
    int miscompares = 0;

    // reference model state
    logic [2:0]   m_src [2][NS];
    logic [2:0]   m_dst [2][NS];
    logic         m2v [2];
    logic [2:0]   m2s [2];
    logic [2:0]   m2d [2];
    logic         m3v [2];
    logic [2:0]   m3d [2];
    logic [W-1:0] m3w [2];
    logic [W-1:0] mproc;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_xfer_pipe #(.DATA_W(W), .NUM_STREAMS(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_stream(slot_stream),
        .ld_en(ld_en), .ld_pipe(ld_pipe), .ld_addr(ld_addr), .ld_src(ld_src), .ld_dst(ld_dst),
        .port_rd_data(port_rd_data), .port_rd_en(port_rd_en), .port_wr_data(port_wr_data),
        .port_wr_en(port_wr_en), .proc_wr_en(proc_wr_en), .proc_wr_data(proc_wr_data),
        .proc_reg(proc_reg), .dst_conflict(dst_conflict)
    );

    task automatic model_reset();
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < NS; s++) begin
                m_src[p][s] = 3'd7;
                m_dst[p][s] = 3'd7;
            end
            m2v[p] = 1'b0; m2s[p] = 3'd7; m2d[p] = 3'd7;
            m3v[p] = 1'b0; m3d[p] = 3'd7; m3w[p] = '0;
        end
        mproc = '0;
    endtask

    task automatic compare(input string tag, input string what,
                           input logic [4*W-1:0] act, input logic [4*W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        logic [3:0]     e_rd;
        logic [3:0]     e_wr;
        logic [4*W-1:0] e_wd;
        logic           e_cf;
        e_rd = '0; e_wr = '0; e_wd = '0;
        for (int p = 0; p < 2; p++)
            if (m2v[p] && m2s[p] < 3'd4) e_rd[m2s[p][1:0]] = 1'b1;
        for (int p = 1; p >= 0; p--)
            if (m3v[p] && m3d[p] < 3'd4) begin
                e_wr[m3d[p][1:0]] = 1'b1;
                e_wd[int'(m3d[p])*W +: W] = m3w[p];
            end
        e_cf = m3v[0] && m3v[1] && m3d[0] == m3d[1] && m3d[0] <= 3'd4;
        compare(tag, "port_rd_en", 512'(port_rd_en), 512'(e_rd));
        compare(tag, "port_wr_en", 512'(port_wr_en), 512'(e_wr));
        compare(tag, "port_wr_data", port_wr_data, e_wd);
        compare(tag, "dst_conflict", 512'(dst_conflict), 512'(e_cf));
        compare(tag, "proc_reg", 512'(proc_reg), 512'(mproc));
    endtask

    task automatic model_step();
        logic [W-1:0] nproc;
        nproc = mproc;
        for (int p = 1; p >= 0; p--)
            if (m3v[p] && m3d[p] == 3'd4) nproc = m3w[p];
        if (proc_wr_en) nproc = proc_wr_data;
        for (int p = 0; p < 2; p++) begin
            m3v[p] = m2v[p];
            m3d[p] = m2v[p] ? m2d[p] : 3'd7;
            if (!m2v[p]) m3w[p] = '0;
            else if (m2s[p] < 3'd4) m3w[p] = port_rd_data[int'(m2s[p])*W +: W];
            else if (m2s[p] == 3'd4) m3w[p] = mproc;
            else m3w[p] = '0;
        end
        for (int p = 0; p < 2; p++) begin
            m2v[p] = slot_valid[p];
            m2s[p] = slot_valid[p] ? m_src[p][slot_stream[p*IW +: IW]] : 3'd7;
            m2d[p] = slot_valid[p] ? m_dst[p][slot_stream[p*IW +: IW]] : 3'd7;
        end
        if (ld_en) begin
            m_src[ld_pipe][ld_addr] = ld_src;
            m_dst[ld_pipe][ld_addr] = ld_dst;
        end
        mproc = nproc;
    endtask

    task automatic cycle(input string tag);
        @(negedge clk);
        check_outputs(tag);
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic lane, input int addr, input logic [2:0] s,
                        input logic [2:0] d, input string tag);
        ld_en = 1'b1; ld_pipe = lane; ld_addr = IW'(addr); ld_src = s; ld_dst = d;
        cycle(tag);
        ld_en = 1'b0;
    endtask

    task automatic issue(input logic [1:0] v, input int s0, input int s1, input string tag);
        slot_valid = v;
        slot_stream = {IW'(s1), IW'(s0)};
        for (int k = 0; k < 4; k++) port_rd_data[k*W +: W] = $urandom;
        cycle(tag);
        slot_valid = '0;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 3; i++) issue(2'b00, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, empty tables yield no transfers
        cycle("R1");
        issue(2'b11, 0, 31, "R1");
        issue(2'b11, 7, 12, "R1");
        drain("R1");

        // R2: load each lane's table, check per-lane separation
        load(1'b0, 3, 3'd0, 3'd1, "R2");
        load(1'b1, 9, 3'd2, 3'd3, "R2");
        issue(2'b01, 9, 0, "R2");
        drain("R2");

        // R7: disjoint port pairs on both lanes in the same slot
        issue(2'b11, 3, 9, "R7");
        issue(2'b11, 3, 9, "R7");
        drain("R7");

        // R3 / R9: processor register as destination and as source
        load(1'b0, 4, 3'd1, 3'd4, "R3");
        load(1'b1, 5, 3'd4, 3'd0, "R3");
        issue(2'b01, 4, 0, "R9");
        drain("R9");
        issue(2'b10, 0, 5, "R9");
        drain("R9");

        // R9: processor write beats lane write in the same cycle
        issue(2'b01, 4, 0, "R9");
        issue(2'b00, 0, 0, "R9");
        proc_wr_en = 1'b1; proc_wr_data = 32'hCAFE_F00D;
        issue(2'b00, 0, 0, "R9");
        proc_wr_en = 1'b0;
        drain("R9");

        // R8: both lanes write port 2, lane 0 wins
        load(1'b0, 6, 3'd0, 3'd2, "R8");
        load(1'b1, 6, 3'd3, 3'd2, "R8");
        issue(2'b11, 6, 6, "R8");
        drain("R8");
        // R8: both lanes into the processor register
        load(1'b1, 10, 3'd3, 3'd4, "R8");
        issue(2'b11, 4, 10, "R8");
        drain("R8");

        // R10: null source writes zero, null destination writes nothing
        load(1'b0, 7, 3'd6, 3'd3, "R10");
        load(1'b1, 8, 3'd1, 3'd5, "R10");
        issue(2'b11, 7, 8, "R10");
        drain("R10");

        // R6: loaded streams with slot invalid are bubbles
        issue(2'b00, 3, 9, "R6");
        issue(2'b00, 6, 6, "R6");
        drain("R6");

        // R4 / R5: random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            ld_en = ($urandom % 8) == 0;
            ld_pipe = 1'($urandom);
            ld_addr = IW'($urandom);
            ld_src = 3'($urandom);
            ld_dst = 3'($urandom);
            proc_wr_en = ($urandom % 16) == 0;
            proc_wr_data = $urandom;
            issue(2'($urandom), int'($urandom % NS), int'($urandom % NS), "R5");
            ld_en = 1'b0;
            proc_wr_en = 1'b0;
        end
        drain("R4");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule